// File: doc/BRIEF.md
# Four-Channel DMA Priority Arbiter

This block sits in front of a four-channel DMA engine and decides which channel may run the next transfer. Each channel drives one request line. The arbiter returns a registered one-hot grant. When several channels ask at once, a two-bit mode field picks the ordering rule. Two rules use a fixed order. The other two rotate: one rotates every channel, and the other rotates only the channels marked in a four-bit selection mask.

The engine keeps `busy_i` high while the granted transfer runs, so the grant cannot change during a burst. It pulses `done_i` when the transfer finishes. The rotation order advances only on that pulse. The channel that finished is reported on `done_ch_o` for one cycle. If the mode or the mask changes, the rotation order returns to its starting state before the next arbitration.

Top module: `dma_prio_arbiter`

## Requirements
- R1: While `rst_n` is low, `grant_o` and `done_ch_o` are all zeros. After reset the rotation order is CH0, CH1, CH2, CH3, from highest to lowest priority.
- R2: `grant_o` is one-hot or all zeros. A grant that was newly arbitrated always names a channel that was requesting in the cycle before.
- R3: With `pri_mode_i` = 00 the order is CH0 > CH1 > CH2 > CH3.
- R4: With `pri_mode_i` = 01 the order is CH0 > CH2 > CH3 > CH1.
- R5: With `pri_mode_i` = 11 all channels rotate. On a `done_i` pulse the granted channel drops to the lowest priority, and the other channels keep their cyclic order.
- R6: With `pri_mode_i` = 10 only the channels whose bit in `rr_sel_i` is 1 rotate. Rotation works as in R5, but only inside that group. The group fills the priority slots whose index equals a selected channel number, in rotation order. An unselected channel N always keeps slot N (slot 0 is the highest).
- R7: The rotation order changes only on a `done_i` pulse while a grant is active. A grant on its own does not change it, and `done_i` with no active grant does nothing.
- R8: While `busy_i` is high and a grant is active, `grant_o` holds its value, whatever the request lines do.
- R9: A `done_i` pulse clears `grant_o` on the next cycle. For that one cycle `done_ch_o` shows the channel that was granted; at all other times it is zero.
- R10: A change of `pri_mode_i` or `rr_sel_i` resets the rotation order to CH0 > CH1 > CH2 > CH3. The reset already applies to the arbitration in the cycle where the change is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | One request line per channel |
| pri_mode_i | input | 2 | Priority rule: 00 fixed A, 01 fixed B, 10 selective rotation, 11 full rotation |
| rr_sel_i | input | 4 | Channels that take part in selective rotation |
| busy_i | input | 1 | Granted transfer in progress; holds the grant |
| done_i | input | 1 | One-cycle pulse at the end of the granted transfer |
| grant_o | output | 4 | Registered one-hot grant, zero when idle |
| done_ch_o | output | 4 | One-hot channel that completed, valid for one cycle |

## Verification
The bench tries every request pattern under every mode, and under every selection mask in selective mode. A swapped position in the second fixed order, or a rotating group that lands in the wrong slots, therefore shows up as a wrong winner.

After each completed transfer, the bench probes the order again with all four channels requesting. A design that rotates on the grant instead of on completion, or that rotates on a stray `done_i` with no grant, would pick a different channel than expected. In selective mode the same probe would catch a design that rotates an unselected channel.

The bench changes the request lines during a busy transfer to catch a grant that does not hold. It also changes only the mask in full-rotation mode, so a design that resets the order on a mode change alone would keep a stale order.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  localparam int NUM_CH = 4;
  localparam int CH_W   = $clog2(NUM_CH);

  typedef logic [CH_W-1:0] ch_t;
  // index 0 carries the highest priority
  typedef ch_t [NUM_CH-1:0] order_t;

  typedef enum logic [1:0] {
    PRI_FIXED_A = 2'b00,
    PRI_FIXED_B = 2'b01,
    PRI_RR_SEL  = 2'b10,
    PRI_RR_ALL  = 2'b11
  } pri_mode_e;

  function automatic order_t identity_order();
    order_t o;
    for (int i = 0; i < NUM_CH; i++) o[i] = ch_t'(i);
    return o;
  endfunction

endpackage

// File: rtl/dma_arb_rotstate.sv
module dma_arb_rotstate
  import dma_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr_i,
  input  logic   upd_i,
  input  ch_t    upd_ch_i,
  output order_t rot_o
);

  order_t rot_q;
  order_t rot_d;
  logic   rot_en;

  always_comb begin
    int j;
    rot_d  = rot_q;
    rot_en = clr_i | upd_i;
    j      = 0;
    if (clr_i) begin
      rot_d = identity_order();
    end else if (upd_i) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (rot_q[i] != upd_ch_i && j < NUM_CH - 1) begin
          rot_d[j] = rot_q[i];
          j++;
        end
      end
      rot_d[NUM_CH-1] = upd_ch_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rot_q <= identity_order();
    end else if (rot_en) begin
      rot_q <= rot_d;
    end
  end

  assign rot_o = rot_q;

  // R7
  rot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_i && !clr_i) |=> $stable(rot_q));

  // R5
  rot_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !clr_i) |=> rot_q[NUM_CH-1] == $past(upd_ch_i));

  // R10
  rot_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> rot_q == identity_order());

endmodule

// File: rtl/dma_arb_order.sv
module dma_arb_order
  import dma_arb_pkg::*;
(
  input  logic [1:0]        mode_i,
  input  logic [NUM_CH-1:0] sel_i,
  input  order_t            rot_i,
  output order_t            eff_o
);

  order_t rlist;

  always_comb begin
    int k;
    int j;
    rlist = identity_order();
    eff_o = identity_order();
    k     = 0;
    j     = 0;
    case (pri_mode_e'(mode_i))
      PRI_FIXED_A: eff_o = identity_order();
      PRI_FIXED_B: begin
        eff_o[0] = ch_t'(0);
        for (int i = 1; i < NUM_CH - 1; i++) eff_o[i] = ch_t'(i + 1);
        eff_o[NUM_CH-1] = ch_t'(1);
      end
      PRI_RR_ALL: eff_o = rot_i;
      default: begin
        // gather the rotating group in its current rotation order
        for (int i = 0; i < NUM_CH; i++) begin
          if (sel_i[rot_i[i]] && k < NUM_CH) begin
            rlist[k] = rot_i[i];
            k++;
          end
        end
        // group members fill the selected slots, others keep their own
        for (int s = 0; s < NUM_CH; s++) begin
          if (sel_i[s] && j < NUM_CH) begin
            eff_o[s] = rlist[j];
            j++;
          end else begin
            eff_o[s] = ch_t'(s);
          end
        end
      end
    endcase
  end

endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
  import dma_arb_pkg::*;
(
  input  order_t            eff_i,
  input  logic [NUM_CH-1:0] req_i,
  output logic [NUM_CH-1:0] pick_o
);

  always_comb begin
    pick_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req_i[eff_i[i]]) begin
        pick_o = '0;
        pick_o[eff_i[i]] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req_i,
  input  logic [1:0]        pri_mode_i,
  input  logic [NUM_CH-1:0] rr_sel_i,
  input  logic              busy_i,
  input  logic              done_i,
  output logic [NUM_CH-1:0] grant_o,
  output logic [NUM_CH-1:0] done_ch_o
);

  logic [1:0]        mode_q;
  logic [NUM_CH-1:0] sel_q;
  logic [NUM_CH-1:0] grant_q, grant_d;
  logic [NUM_CH-1:0] done_ch_q, done_ch_d;
  logic [NUM_CH-1:0] pick;
  logic              cfg_chg;
  logic              hold;
  logic              rot_upd;
  ch_t               gch;
  order_t            rot_q, rot_eff, eff;

  assign cfg_chg = (pri_mode_i != mode_q) || (rr_sel_i != sel_q);
  assign rot_eff = cfg_chg ? identity_order() : rot_q;
  assign hold    = busy_i && (|grant_q);

  dma_arb_rotstate u_rot (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (cfg_chg),
    .upd_i    (rot_upd),
    .upd_ch_i (gch),
    .rot_o    (rot_q)
  );

  dma_arb_order u_order (
    .mode_i (pri_mode_i),
    .sel_i  (rr_sel_i),
    .rot_i  (rot_eff),
    .eff_o  (eff)
  );

  dma_arb_pick u_pick (
    .eff_i  (eff),
    .req_i  (req_i),
    .pick_o (pick)
  );

  always_comb begin
    gch = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (grant_q[i]) gch = ch_t'(i);
    end
  end

  always_comb begin
    rot_upd = 1'b0;
    if (done_i && (|grant_q)) begin
      if (pri_mode_e'(pri_mode_i) == PRI_RR_ALL) rot_upd = 1'b1;
      else if (pri_mode_e'(pri_mode_i) == PRI_RR_SEL) rot_upd = rr_sel_i[gch];
    end
  end

  always_comb begin
    if (done_i)    grant_d = '0;
    else if (hold) grant_d = grant_q;
    else           grant_d = pick;
    done_ch_d = done_i ? grant_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q   <= '0;
      done_ch_q <= '0;
      mode_q    <= '0;
      sel_q     <= '0;
    end else begin
      grant_q   <= grant_d;
      done_ch_q <= done_ch_d;
      mode_q    <= pri_mode_i;
      sel_q     <= rr_sel_i;
    end
  end

  assign grant_o   = grant_q;
  assign done_ch_o = done_ch_q;

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q));

  // R2
  grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|grant_q) && !$past(done_i) && !($past(busy_i) && (|$past(grant_q))))
      |-> (|(grant_q & $past(req_i))));

  // R8
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && (|grant_q) && !done_i) |=> grant_q == $past(grant_q));

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> (grant_q == '0) && (done_ch_q == $past(grant_q)));

endmodule

// File: tb/dma_prio_arbiter_test.sv
module dma_prio_arbiter_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] req;
  logic [1:0] mode;
  logic [3:0] rc;
  logic       busy;
  logic       done;
  logic [3:0] grant;
  logic [3:0] done_ch;

  int checks = 0;
  int errors = 0;
  int m_rot[4];
  int m_mode = 0;
  logic [3:0] m_rc = 4'h0;

  always #5 clk = ~clk;

  dma_prio_arbiter uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req),
    .pri_mode_i (mode),
    .rr_sel_i   (rc),
    .busy_i     (busy),
    .done_i     (done),
    .grant_o    (grant),
    .done_ch_o  (done_ch)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chk_onehot();
    checks++;
    if ($countones(grant) > 1) begin
      errors++;
      $display("FAIL R2 actual=%b expected=one-hot or zero", grant);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < 4; i++) m_rot[i] = i;
  endfunction

  function automatic logic [3:0] exp_pick(logic [3:0] rq);
    int rank[4];
    int k;
    int best;
    logic [3:0] res;
    for (int c = 0; c < 4; c++) rank[c] = c;
    if (m_mode == 1) begin
      rank[1] = 3; rank[2] = 1; rank[3] = 2;
    end else if (m_mode == 3) begin
      for (int i = 0; i < 4; i++) rank[m_rot[i]] = i;
    end else if (m_mode == 2) begin
      k = 0;
      for (int i = 0; i < 4; i++) begin
        if (m_rc[m_rot[i]]) begin
          int n;
          n = 0;
          for (int s = 0; s < 4; s++) begin
            if (m_rc[s]) begin
              if (n == k) rank[m_rot[i]] = s;
              n++;
            end
          end
          k++;
        end
      end
    end
    res  = 4'h0;
    best = 99;
    for (int c = 0; c < 4; c++) begin
      if (rq[c] && rank[c] < best) begin
        best = rank[c];
        res  = 4'h0;
        res[c] = 1'b1;
      end
    end
    return res;
  endfunction

  function automatic void model_done(logic [3:0] g);
    int gc;
    int tmp[4];
    int j;
    gc = 0;
    for (int c = 0; c < 4; c++) if (g[c]) gc = c;
    if (m_mode == 3 || (m_mode == 2 && m_rc[gc])) begin
      j = 0;
      for (int i = 0; i < 4; i++) begin
        if (m_rot[i] != gc) begin
          tmp[j] = m_rot[i];
          j++;
        end
      end
      tmp[3] = gc;
      for (int i = 0; i < 4; i++) m_rot[i] = tmp[i];
    end
  endfunction

  function automatic string mode_tag(int md);
    case (md)
      0: return "R3";
      1: return "R4";
      2: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic set_cfg(input int md, input logic [3:0] sel);
    mode = 2'(md);
    rc   = sel;
    if (md != m_mode || sel != m_rc) model_reset();
    m_mode = md;
    m_rc   = sel;
  endtask

  // starts right after a falling edge
  task automatic arb(input logic [3:0] rq, input string tag);
    req  = rq;
    busy = 1'b0;
    done = 1'b0;
    @(negedge clk);
    chk(tag, grant, exp_pick(rq));
    chk_onehot();
  endtask

  task automatic xfer(input logic [3:0] rq, input string tag);
    logic [3:0] e;
    req  = rq;
    busy = 1'b0;
    done = 1'b0;
    @(negedge clk);
    e = exp_pick(rq);
    chk(tag, grant, e);
    busy = 1'b1;
    req  = ~rq;
    @(negedge clk);
    chk("R8", grant, e);
    done = 1'b1;
    @(negedge clk);
    chk("R9", grant, 4'h0);
    chk("R9", done_ch, e);
    model_done(e);
    done = 1'b0;
    busy = 1'b0;
    req  = 4'h0;
    @(negedge clk);
    chk("R9", done_ch, 4'h0);
  endtask

  task automatic idle_done();
    req  = 4'h0;
    busy = 1'b0;
    done = 1'b1;
    @(negedge clk);
    chk("R7", done_ch, 4'h0);
    done = 1'b0;
    @(negedge clk);
    chk("R7", done_ch, 4'h0);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    model_reset();
    rst_n = 1'b0;
    req   = 4'hF;
    mode  = 2'd0;
    rc    = 4'h0;
    busy  = 1'b0;
    done  = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", grant, 4'h0);
    chk("R1", done_ch, 4'h0);
    rst_n = 1'b1;
    set_cfg(3, 4'h0);
    arb(4'hF, "R1");

    for (int md = 0; md < 4; md++) begin
      for (int sel = 0; sel < 16; sel++) begin
        if (md != 2 && sel != 0) continue;
        set_cfg(md, 4'(sel));
        for (int r = 1; r < 16; r++) arb(4'(r), mode_tag(md));
        for (int t = 0; t < 8; t++) begin
          logic [3:0] pat;
          pat = (t % 2 == 0) ? 4'hF : 4'(((t * 7 + 5) % 15) + 1);
          xfer(pat, mode_tag(md));
          if (t == 3) idle_done();
          // R7: a grant with no done leaves the order alone
          arb(4'hF, "R7");
          arb(4'hF, "R7");
        end
      end
    end

    // R10: mask change alone restores the start order
    set_cfg(3, 4'h0);
    xfer(4'hF, "R5");
    xfer(4'hF, "R5");
    arb(4'hF, "R5");
    set_cfg(3, 4'h5);
    arb(4'hF, "R10");
    chk("R10", grant, 4'b0001);

    report();
    $finish;
  end

endmodule